// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block produces the external memory bus timing of an 8-bit microcontroller from the oscillator clock. It divides the clock into 12-clock machine cycles and runs an address-latch strobe that keeps its rate whatever the bus is doing. On top of that rhythm it places code fetches, which raise a code read strobe, and external data reads or writes. The low address byte and the data byte share one bus. The latch strobe tells an external register when that bus holds the low address. A second output carries the high address byte.

The core asks for work through a one-clock handshake. This happens once per machine cycle, in the last clock of the cycle. A fetch request fills one machine cycle: it fetches at the program counter in the first half and at the next address in the second half. A data request fills two machine cycles. The first half fetches the opcode. The second half latches the data address. The next machine cycle drops its first latch pulse and holds the read or write strobe for its whole first half. It then fetches at the following code address in its second half.

A level on the code-select input, sampled while reset is active, decides whether low code addresses come from internal memory, which raises no code strobe. Reset takes effect only after the reset input has been high for two full machine cycles.

Top module: `xbus_sequencer`

## Requirements
- R1: With no data access in progress, `addr_latch` rises twice per 12-clock machine cycle. It is high in slots 1-2 and 7-8, where slot 0 is the clock after the handshake accept.
- R2: A data access spans two machine cycles (24 clocks) and yields exactly three `addr_latch` pulses. The slot 1-2 pulse of its second machine cycle is omitted.
- R3: `code_rd_n` is low in slots 3-5 of each externally fetched half-cycle. This gives two pulses per fetch cycle and two in total across the two machine cycles of a data access.
- R4: When `boot_int` was 1 during reset, a fetch at an address below 16384 keeps `code_rd_n` high. Fetches at 16384 and above are external. When `boot_int` was 0, every fetch is external.
- R5: `bus_hi` carries the fetch address bits 15:8 during fetch halves. During the data halves it carries `req_addr[15:8]` for pointer accesses (`req_ptr`=1) and `hi_page` for register accesses (`req_ptr`=0). When idle it carries `hi_page`.
- R6: In slots 0-2 of every fetch half and data-address half, `bus_lo_oe` is 1 and `bus_lo_o` holds the low address byte. For data this is `req_addr[7:0]`.
- R7: In slots 0-5 of the second machine cycle of a data access, `data_wr_n` is low for a write (`req_write`=1) and `data_rd_n` is low for a read. A write drives `req_wdata` with `bus_lo_oe`=1. A read keeps `bus_lo_oe`=0.
- R8: When `code_rd_n` or `data_rd_n` rises, `rdata` takes the `bus_lo_i` value present in the last low clock, and `rdata_vld` is 1 for that one clock.
- R9: The sequencer resets only after `rst` has been high for 24 consecutive clocks. While in reset all strobes are high and `req_ready` and `rdata_vld` are 0. A shorter high pulse on `rst` is ignored, and `boot_int` is then not resampled.
- R10: `req_ready` is 1 for one clock in slot 11 of each machine cycle, except in the first machine cycle of a data access. `req_data`=1 selects a data access and `req_data`=0 a plain fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Active-high reset, filtered over two machine cycles |
| boot_int | input | 1 | Code-space select, sampled during reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted at this clock when valid |
| req_data | input | 1 | 1 = data access, 0 = code fetch only |
| req_write | input | 1 | Data direction, 1 = write |
| req_ptr | input | 1 | 1 = 16-bit pointer address, 0 = 8-bit register address |
| req_pc | input | 16 | Code fetch address |
| req_addr | input | 16 | Data address |
| req_wdata | input | 8 | Data byte to write |
| hi_page | input | 8 | Port-2 output register contents |
| bus_lo_i | input | 8 | Low bus input |
| addr_latch | output | 1 | Address latch strobe, active high |
| code_rd_n | output | 1 | Code read strobe, active low |
| data_rd_n | output | 1 | Data read strobe, active low |
| data_wr_n | output | 1 | Data write strobe, active low |
| bus_lo_o | output | 8 | Low bus output value |
| bus_lo_oe | output | 1 | Low bus output enable |
| bus_hi | output | 8 | High address byte |
| rdata | output | 8 | Captured read byte |
| rdata_vld | output | 1 | Capture pulse |

## Verification
The assertions assume that the core holds `rst` high for at least 24 clocks before relying on any timing. They also assume that it only changes request fields while `req_ready` is low or at the accepting clock. The bench meets both conditions. It drives inputs on falling edges, waits for `req_ready` before it presents a request, and drops `req_valid` right after acceptance. It holds every reset for 30 clocks, except for one deliberately short pulse that tests the filter. It models the external memory by returning one fixed byte under the data read strobe and a different one otherwise, so each capture can be traced to the strobe that caused it.

// File: rtl/xbus_sequencer.sv
module xbus_sequencer #(
  parameter int CYC_CLKS     = 12,
  parameter int RST_MC       = 2,
  parameter int INT_CODE_TOP = 16384
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        boot_int,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_data,
  input  logic        req_write,
  input  logic        req_ptr,
  input  logic [15:0] req_pc,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  input  logic [7:0]  hi_page,
  input  logic [7:0]  bus_lo_i,
  output logic        addr_latch,
  output logic        code_rd_n,
  output logic        data_rd_n,
  output logic        data_wr_n,
  output logic [7:0]  bus_lo_o,
  output logic        bus_lo_oe,
  output logic [7:0]  bus_hi,
  output logic [7:0]  rdata,
  output logic        rdata_vld
);
  localparam int HALF     = CYC_CLKS / 2;
  localparam int SW       = $clog2(CYC_CLKS);
  localparam int RST_CLKS = RST_MC * CYC_CLKS;
  localparam int RW       = $clog2(RST_CLKS + 1);
  localparam logic [16:0] CODE_LIM = 17'(INT_CODE_TOP);
  localparam logic [SW-1:0] LAST = SW'(CYC_CLKS - 1);
  localparam logic [SW-1:0] AL_A = SW'(1);
  localparam logic [SW-1:0] AL_B = SW'(2);
  localparam logic [SW-1:0] STB0 = SW'(3);
  localparam logic [SW-1:0] HEND = SW'(HALF - 1);

  typedef enum logic [1:0] {OP_IDLE, OP_FETCH, OP_D1, OP_D2} op_t;

  logic [RW-1:0] rcnt;
  logic          irst;
  logic [SW-1:0] slot, off;
  op_t           op;
  logic          int_ok, wr, ptr, second;
  logic [15:0]   pc, addr, fa;
  logic [7:0]    wdata;
  logic          fetch_half, daddr_half, strobe_half, ext_fetch, addr_phase, accept;

  always_ff @(posedge clk) begin
    if (!rst) rcnt <= '0;
    else if (rcnt != RW'(RST_CLKS)) rcnt <= rcnt + 1'b1;
  end
  assign irst = (rcnt == RW'(RST_CLKS));

  assign req_ready = !irst && slot == LAST && op != OP_D1;
  assign accept    = req_ready && req_valid;

  always_ff @(posedge clk) begin
    if (irst) begin
      slot   <= '0;
      op     <= OP_IDLE;
      int_ok <= boot_int;
      pc     <= '0;
      addr   <= '0;
      wdata  <= '0;
      wr     <= 1'b0;
      ptr    <= 1'b0;
    end else begin
      slot <= (slot == LAST) ? '0 : slot + 1'b1;
      if (slot == LAST) begin
        if (op == OP_D1) op <= OP_D2;
        else if (accept) begin
          op    <= req_data ? OP_D1 : OP_FETCH;
          pc    <= req_pc;
          addr  <= req_addr;
          wdata <= req_wdata;
          wr    <= req_write;
          ptr   <= req_ptr;
        end else op <= OP_IDLE;
      end
    end
  end

  assign second      = slot >= SW'(HALF);
  assign off         = second ? slot - SW'(HALF) : slot;
  assign fa          = second ? pc + 16'd1 : pc;
  assign fetch_half  = op == OP_FETCH || (op == OP_D1 && !second) || (op == OP_D2 && second);
  assign daddr_half  = op == OP_D1 && second;
  assign strobe_half = op == OP_D2 && !second;
  assign ext_fetch   = !(int_ok && {1'b0, fa} < CODE_LIM);
  assign addr_phase  = (fetch_half || daddr_half) && off <= AL_B;

  assign addr_latch = (off == AL_A || off == AL_B) && !strobe_half;
  assign code_rd_n  = !(fetch_half && ext_fetch && off >= STB0);
  assign data_rd_n  = !(strobe_half && !wr);
  assign data_wr_n  = !(strobe_half && wr);
  assign bus_lo_oe  = addr_phase || (wr && (strobe_half || daddr_half));
  assign bus_lo_o   = !addr_phase ? wdata : fetch_half ? fa[7:0] : addr[7:0];
  assign bus_hi     = fetch_half ? fa[15:8] :
                      ((daddr_half || strobe_half) && ptr) ? addr[15:8] : hi_page;

  always_ff @(posedge clk) begin
    if (irst) begin
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      rdata_vld <= (!code_rd_n || !data_rd_n) && off == HEND;
      if ((!code_rd_n || !data_rd_n) && off == HEND) rdata <= bus_lo_i;
    end
  end
endmodule

// File: rtl/xbus_sequencer_chk.sv
module xbus_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic addr_latch,
  input logic code_rd_n,
  input logic data_rd_n,
  input logic data_wr_n,
  input logic bus_lo_oe,
  input logic rdata_vld
);
  AST_LATCH_TWO_CLKS: assert property (@(posedge clk) disable iff (rst)
    addr_latch && $past(addr_latch) |=> !addr_latch); // R1
  AST_STROBES_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({addr_latch, !code_rd_n, !data_rd_n, !data_wr_n})); // R2
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    !data_wr_n |-> bus_lo_oe); // R7
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (!data_rd_n || !code_rd_n) |-> !bus_lo_oe); // R7
  AST_CAPTURE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    rdata_vld |-> $past(!code_rd_n || !data_rd_n)); // R8
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready); // R10
endmodule

bind xbus_sequencer xbus_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .addr_latch(addr_latch),
  .code_rd_n(code_rd_n), .data_rd_n(data_rd_n), .data_wr_n(data_wr_n),
  .bus_lo_oe(bus_lo_oe), .rdata_vld(rdata_vld)
);

// File: tb/xbus_sequencer_bench.sv
module xbus_sequencer_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, boot_int = 1'b0, req_valid = 1'b0, req_data = 1'b0;
  logic req_write = 1'b0, req_ptr = 1'b0;
  logic [15:0] req_pc = '0, req_addr = '0;
  logic [7:0] req_wdata = '0, hi_page = 8'h9C;
  logic [7:0] bus_lo_i, bus_lo_o, bus_hi, rdata;
  logic req_ready, addr_latch, code_rd_n, data_rd_n, data_wr_n, bus_lo_oe, rdata_vld;

  assign bus_lo_i = !data_rd_n ? 8'hA5 : 8'h3C;

  xbus_sequencer u_xbus_sequencer (
    .clk(clk), .rst(rst), .boot_int(boot_int), .req_valid(req_valid),
    .req_ready(req_ready), .req_data(req_data), .req_write(req_write),
    .req_ptr(req_ptr), .req_pc(req_pc), .req_addr(req_addr),
    .req_wdata(req_wdata), .hi_page(hi_page), .bus_lo_i(bus_lo_i),
    .addr_latch(addr_latch), .code_rd_n(code_rd_n), .data_rd_n(data_rd_n),
    .data_wr_n(data_wr_n), .bus_lo_o(bus_lo_o), .bus_lo_oe(bus_lo_oe),
    .bus_hi(bus_hi), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic s_al[36], s_ps[36], s_rd[36], s_wr[36], s_oe[36], s_vld[36], s_rdy[36];
  logic [7:0] s_hi[36], s_lo[36], s_rdat[36];

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  task automatic store(int k);
    s_al[k] = addr_latch; s_ps[k] = code_rd_n; s_rd[k] = data_rd_n; s_wr[k] = data_wr_n;
    s_oe[k] = bus_lo_oe; s_vld[k] = rdata_vld; s_rdy[k] = req_ready;
    s_hi[k] = bus_hi; s_lo[k] = bus_lo_o; s_rdat[k] = rdata;
  endtask

  function automatic int rises(int n);
    int c = 0;
    for (int k = 1; k < n; k++) if (s_al[k] && !s_al[k-1]) c++;
    return c;
  endfunction

  function automatic int falls_ps(int n);
    int c = 0;
    for (int k = 1; k < n; k++) if (!s_ps[k] && s_ps[k-1]) c++;
    return c;
  endfunction

  function automatic int falls_rd(int n);
    int c = 0;
    for (int k = 1; k < n; k++) if (!s_rd[k] && s_rd[k-1]) c++;
    return c;
  endfunction

  function automatic int falls_wr(int n);
    int c = 0;
    for (int k = 1; k < n; k++) if (!s_wr[k] && s_wr[k-1]) c++;
    return c;
  endfunction

  task automatic run(input logic d, input logic w, input logic p,
                     input logic [15:0] pc, input logic [15:0] a, input logic [7:0] wd, input int n);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_data = d; req_write = w; req_ptr = p;
    req_pc = pc; req_addr = a; req_wdata = wd;
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      store(k);
    end
  endtask

  task automatic do_reset(input logic b, input int len);
    @(negedge clk);
    rst = 1'b1; boot_int = b;
    repeat (len) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (30) @(negedge clk);
    chk("R9 reset code_rd_n", code_rd_n, 1);
    chk("R9 reset data_rd_n", data_rd_n, 1);
    chk("R9 reset data_wr_n", data_wr_n, 1);
    chk("R9 reset rdata_vld", rdata_vld, 0);
    chk("R9 reset req_ready", req_ready, 0);
    rst = 1'b0;

    // R1 R10 idle rhythm
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    for (int k = 0; k < 36; k++) begin @(negedge clk); store(k); end
    begin
      int r = 0;
      for (int k = 0; k < 36; k++) r += s_rdy[k];
      chk("R10 ready per 3 idle cycles", r, 3);
    end
    chk("R1 idle latch pulses", rises(36), 6);
    chk("R3 idle code strobes", falls_ps(36), 0);

    // fetch only, external
    run(0, 0, 0, 16'h12FF, 16'h0, 8'h0, 12);
    chk("R1 fetch latch pulses", rises(12), 2);
    chk("R1 latch slot 1", s_al[1], 1);
    chk("R1 latch slot 3", s_al[3], 0);
    chk("R3 fetch code strobes", falls_ps(12), 2);
    chk("R3 code strobe slot 3", s_ps[3], 0);
    chk("R5 fetch hi first half", s_hi[1], 8'h12);
    chk("R5 fetch hi second half", s_hi[7], 8'h13);
    chk("R6 fetch lo first half", s_lo[1], 8'hFF);
    chk("R6 fetch lo second half", s_lo[7], 8'h00);
    chk("R6 fetch oe slot 2", s_oe[2], 1);
    chk("R8 code capture value", s_rdat[6], 8'h3C);
    chk("R8 code capture pulse", s_vld[6], 1);

    // pointer read
    run(1, 0, 1, 16'h2000, 16'hBEEF, 8'h0, 24);
    chk("R2 ptr read latch pulses", rises(24), 3);
    chk("R2 latch omitted slot 13", s_al[13], 0);
    chk("R3 ptr read code strobes", falls_ps(24), 2);
    chk("R7 read strobe count", falls_rd(24), 1);
    chk("R7 read strobe slot 12", s_rd[12], 0);
    chk("R7 read strobe slot 17", s_rd[17], 0);
    chk("R7 read strobe slot 18", s_rd[18], 1);
    chk("R7 read bus released", s_oe[14], 0);
    chk("R7 no write strobe", falls_wr(24), 0);
    chk("R5 ptr hi address half", s_hi[7], 8'hBE);
    chk("R5 ptr hi strobe half", s_hi[13], 8'hBE);
    chk("R6 data lo address", s_lo[7], 8'hEF);
    chk("R8 read capture value", s_rdat[18], 8'hA5);
    chk("R8 read capture pulse", s_vld[18], 1);
    chk("R5 fetch hi after data", s_hi[19], 8'h20);

    // register write
    run(1, 1, 0, 16'h2100, 16'h0042, 8'h5A, 24);
    chk("R2 reg write latch pulses", rises(24), 3);
    chk("R3 reg write code strobes", falls_ps(24), 2);
    chk("R7 write strobe count", falls_wr(24), 1);
    chk("R7 write no read strobe", falls_rd(24), 0);
    chk("R7 write data on bus", s_lo[13], 8'h5A);
    chk("R7 write oe", s_oe[13], 1);
    chk("R5 reg hi address half", s_hi[7], 8'h9C);
    chk("R5 reg hi strobe half", s_hi[13], 8'h9C);
    chk("R6 reg lo address", s_lo[7], 8'h42);

    // internal code space
    do_reset(1, 30);
    run(0, 0, 0, 16'h3FFE, 16'h0, 8'h0, 12);
    chk("R4 internal both halves", falls_ps(12), 0);
    chk("R1 internal latch pulses", rises(12), 2);
    run(0, 0, 0, 16'h3FFF, 16'h0, 8'h0, 12);
    chk("R4 boundary one external half", falls_ps(12), 1);
    chk("R4 boundary strobe second half", s_ps[9], 0);
    run(0, 0, 0, 16'h8000, 16'h0, 8'h0, 12);
    chk("R4 high address external", falls_ps(12), 2);

    // short reset pulse ignored
    do_reset(0, 12);
    run(0, 0, 0, 16'h1000, 16'h0, 8'h0, 12);
    chk("R9 short pulse keeps code select", falls_ps(12), 0);
    do_reset(0, 30);
    run(0, 0, 0, 16'h1000, 16'h0, 8'h0, 12);
    chk("R4 external after full reset", falls_ps(12), 2);

    finish_run();
  end
endmodule